// File: doc/BRIEF.md
# Selectable Burst Address Sequencer

This block produces the addresses of a four-beat memory burst. A starting address is captured on a rising clock edge when either of two load strobes is high. One strobe serves the processor and the other serves the memory controller. On each later edge where the advance input is high, the block steps to the next beat. The upper address bits stay fixed for the whole burst. Only the low two bits move, driven by a two-bit beat counter.

A static order input selects how the low bits move. In the wrapping linear order they count upward modulo four from the loaded value. In the interleaved order they are the loaded value XORed with the beat number. When no strobe and no advance are present, the address holds, which suspends the burst. A strobe that arrives in the middle of a burst starts a fresh burst at the new address. This gives the usual pattern: a first access with some latency, then one new address per clock.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high on a rising edge, `addr_out` is all zeros after that edge.
- R2: When `cpu_strobe` (active high) is sampled high, `addr_out` equals the `load_addr` value sampled on that edge.
- R3: When `ctl_strobe` (active high) is sampled high, alone or together with `cpu_strobe`, `addr_out` equals the sampled `load_addr` after that edge.
- R4: With `interleave_mode` = 0, after n advances since a load, `addr_out[1:0]` = (loaded low bits + n) mod 4, e.g. start 1 gives 1,2,3,0.
- R5: With `interleave_mode` = 1, after n advances since a load, `addr_out[1:0]` = loaded low bits XOR (n mod 4), e.g. start 1 gives 1,0,3,2.
- R6: The beat count wraps after the fourth beat, so four advances return `addr_out[1:0]` to the loaded low bits.
- R7: On an edge with both strobes and `advance` low, `addr_out` keeps its value (burst suspend).
- R8: A strobe takes priority over `advance` and restarts the beat count at zero with the newly loaded address.
- R9: `addr_out[ADDR_W-1:2]` changes only on an edge where a strobe is sampled high, or on reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_strobe | input | 1 | Processor address load strobe, active high |
| ctl_strobe | input | 1 | Controller address load strobe, active high |
| advance | input | 1 | Step to the next beat, active high |
| interleave_mode | input | 1 | 0 = linear wrapping order, 1 = XOR interleaved order; held static |
| load_addr | input | ADDR_W | Starting address captured on a strobe |
| addr_out | output | ADDR_W | Current burst address |

## Verification
On every cycle, assertions check several rules: the reset value, capture of the address on either strobe, the hold during suspend, that the upper bits stay fixed without a strobe, the plus-one step in linear order, and the count restart on a new load. Some behaviours depend on the loaded start and the beat number together: the full interleaved order, the wrap back to the start after four beats, and priority when a strobe and advance coincide mid-burst. Only the bench scenarios, compared against a behavioural model, can show these.

// File: rtl/bas_pkg.sv
package bas_pkg;
    localparam int BEAT_W = 2;
    typedef logic [BEAT_W-1:0] beat_t;
    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;
endpackage

// File: rtl/bas_order.sv
module bas_order
    import bas_pkg::*;
(
    input  beat_t start_i,
    input  beat_t beat_i,
    input  logic  xor_mode_i,
    output beat_t low_o
);
    beat_t linear_w;
    beat_t xored_w;

    always_comb begin
        linear_w = beat_t'(start_i + beat_i);
        xored_w  = start_i ^ beat_i;
        low_o    = (order_e'(xor_mode_i) == ORD_XOR) ? xored_w : linear_w;
    end
endmodule

// File: rtl/bas_ctrl.sv
module bas_ctrl
    import bas_pkg::*;
#(
    parameter int HI_W = 18
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_i,
    input  logic            advance_i,
    input  logic [HI_W-1:0] load_hi_i,
    input  beat_t           load_lo_i,
    output logic [HI_W-1:0] hi_o,
    output beat_t           start_o,
    output beat_t           beat_o
);
    typedef struct packed {
        logic [HI_W-1:0] hi;
        beat_t           start;
        beat_t           beat;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.hi    = load_hi_i;
            st_d.start = load_lo_i;
            st_d.beat  = '0;
        end else if (advance_i) begin
            st_d.beat = beat_t'(st_q.beat + beat_t'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign hi_o    = st_q.hi;
    assign start_o = st_q.start;
    assign beat_o  = st_q.beat;

    // R8: a load always restarts the beat count
    assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (beat_o == '0));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bas_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_strobe,
    input  logic              ctl_strobe,
    input  logic              advance,
    input  logic              interleave_mode,
    input  logic [ADDR_W-1:0] load_addr,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int HI_W = ADDR_W - BEAT_W;

    logic            load_w;
    logic [HI_W-1:0] hi_w;
    beat_t           start_w;
    beat_t           beat_w;
    beat_t           low_w;

    assign load_w = cpu_strobe | ctl_strobe;

    bas_ctrl #(.HI_W(HI_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .load_i    (load_w),
        .advance_i (advance),
        .load_hi_i (load_addr[ADDR_W-1:BEAT_W]),
        .load_lo_i (load_addr[BEAT_W-1:0]),
        .hi_o      (hi_w),
        .start_o   (start_w),
        .beat_o    (beat_w)
    );

    bas_order u_order (
        .start_i    (start_w),
        .beat_i     (beat_w),
        .xor_mode_i (interleave_mode),
        .low_o      (low_w)
    );

    assign addr_out = {hi_w, low_w};

    // R1: reset clears the address
    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (addr_out == '0));

    // R2 / R3: either strobe captures the address
    assert_load_R2_R3: assert property (@(posedge clk) disable iff (rst)
        (cpu_strobe || ctl_strobe) |=> (addr_out == $past(load_addr)));

    // R7: suspend holds the address while the order input is steady
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!cpu_strobe && !ctl_strobe && !advance)
            |=> (!$stable(interleave_mode) || $stable(addr_out)));

    // R9: upper bits move only on a load
    assert_upper_R9: assert property (@(posedge clk) disable iff (rst)
        (!cpu_strobe && !ctl_strobe)
            |=> $stable(addr_out[ADDR_W-1:BEAT_W]));

    // R4: linear order steps by one modulo four
    assert_linear_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!cpu_strobe && !ctl_strobe && advance && !interleave_mode)
            |=> ($stable(interleave_mode) == 1'b0) ||
                (addr_out[BEAT_W-1:0] == beat_t'($past(addr_out[BEAT_W-1:0]) + beat_t'(1))));
endmodule

// File: tb/burst_addr_seq_tb.sv
`timescale 1ns/1ps
module burst_addr_seq_tb;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_strobe = 1'b0;
    logic          ctl_strobe = 1'b0;
    logic          advance = 1'b0;
    logic          interleave_mode = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [AW-1:0] addr_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // behavioural model state
    int m_hi = 0;
    int m_start = 0;
    int m_beat = 0;

    always #2 clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW)) u_dut (
        .clk             (clk),
        .rst             (rst),
        .cpu_strobe      (cpu_strobe),
        .ctl_strobe      (ctl_strobe),
        .advance         (advance),
        .interleave_mode (interleave_mode),
        .load_addr       (load_addr),
        .addr_out        (addr_out)
    );

    function automatic int model_addr();
        int lo;
        if (interleave_mode) lo = m_start ^ m_beat;
        else                 lo = (m_start + m_beat) % 4;
        return m_hi * 4 + lo;
    endfunction

    task automatic check(input string tag, input int exp);
        checks++;
        if (int'(addr_out) != exp) begin
            errors++;
            $display("FAIL %s addr_out=%0h expected=%0h", tag, addr_out, exp);
        end
    endtask

    // one cycle: drive on negedge, model follows the edge, compare next negedge
    task automatic step(input bit c, input bit k, input bit a, input int ad, input string tag);
        cpu_strobe = c;
        ctl_strobe = k;
        advance    = a;
        load_addr  = AW'(ad);
        @(posedge clk);
        #0.1;
        if (rst) begin
            m_hi = 0; m_start = 0; m_beat = 0;
        end else if (c || k) begin
            m_hi = ad / 4; m_start = ad % 4; m_beat = 0;
        end else if (a) begin
            m_beat = (m_beat + 1) % 4;
        end
        @(negedge clk);
        check(tag, model_addr());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step(1'b0, 1'b0, 1'b1, 'h3, "R1 reset");
        step(1'b1, 1'b0, 1'b0, 'h5, "R1 reset beats strobe");
        rst = 1'b0;

        // linear order, start 1
        interleave_mode = 1'b0;
        step(1'b1, 1'b0, 1'b0, 'hABC1, "R2 cpu load");
        checks++; if (addr_out != 20'hABC1) begin errors++; $display("FAIL R2 addr_out=%0h expected=abc1", addr_out); end
        step(1'b0, 1'b0, 1'b1, 0, "R4 linear beat1");
        step(1'b0, 1'b0, 1'b1, 0, "R4 linear beat2");
        step(1'b0, 1'b0, 1'b1, 0, "R4 linear beat3");
        checks++; if (addr_out[1:0] != 2'd0) begin errors++; $display("FAIL R4 low=%0d expected=0", addr_out[1:0]); end
        step(1'b0, 1'b0, 1'b1, 'h777, "R6 linear wrap");
        checks++; if (addr_out != 20'hABC1) begin errors++; $display("FAIL R6 addr_out=%0h expected=abc1", addr_out); end

        // suspend
        step(1'b0, 1'b0, 1'b0, 'hFFFF, "R7 suspend");
        step(1'b0, 1'b0, 1'b0, 'h1234, "R7 suspend again");
        step(1'b0, 1'b0, 1'b1, 'h1234, "R9 upper fixed on advance");

        // interleaved order, start 1: 1,0,3,2
        interleave_mode = 1'b1;
        step(1'b0, 1'b1, 1'b0, 'h40001, "R3 ctl load");
        checks++; if (addr_out != 20'h40001) begin errors++; $display("FAIL R3 addr_out=%0h expected=40001", addr_out); end
        step(1'b0, 1'b0, 1'b1, 0, "R5 xor beat1");
        checks++; if (addr_out[1:0] != 2'd0) begin errors++; $display("FAIL R5 low=%0d expected=0", addr_out[1:0]); end
        step(1'b0, 1'b0, 1'b1, 0, "R5 xor beat2");
        checks++; if (addr_out[1:0] != 2'd3) begin errors++; $display("FAIL R5 low=%0d expected=3", addr_out[1:0]); end
        step(1'b0, 1'b0, 1'b1, 0, "R5 xor beat3");
        checks++; if (addr_out[1:0] != 2'd2) begin errors++; $display("FAIL R5 low=%0d expected=2", addr_out[1:0]); end
        step(1'b0, 1'b0, 1'b1, 0, "R6 xor wrap");

        // restart mid-burst, strobe beats advance, both strobes together
        step(1'b0, 1'b0, 1'b1, 0, "R5 xor beat1 again");
        step(1'b1, 1'b0, 1'b1, 'h2222E, "R8 restart with advance");
        checks++; if (addr_out != 20'h2222E) begin errors++; $display("FAIL R8 addr_out=%0h expected=2222e", addr_out); end
        step(1'b0, 1'b0, 1'b1, 0, "R8 first beat after restart");
        step(1'b1, 1'b1, 1'b0, 'h13, "R3 both strobes");
        for (int s = 0; s < 4; s++) begin
            interleave_mode = s[0];
            step(1'b1, 1'b0, 1'b0, 'h100 + s, "R2 load start sweep");
            for (int n = 0; n < 5; n++)
                step(1'b0, 1'b0, 1'b1, 'h3FF, s[0] ? "R5 sweep" : "R4 sweep");
        end
        step(1'b0, 1'b0, 1'b0, 0, "R9 upper held");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule